// File: doc/BRIEF.md
# Tagged byte holding pipeline

The block carries bytes through two holding stages between a 64-slot byte FIFO and the byte register that feeds a DMA engine, inside a parallel port controller that supports the ECP protocol. A direction field in its control register picks the flow. In receive, bytes arrive from the port side and are written into the FIFO. In transmit, bytes are read out of the FIFO and handed to the DMA buffer register. Each byte travels together with a tag flag. The flag marks it as an ECP channel address or as a run-length code.

In receive, a tagged byte may take one of two paths. If run-length handling is enabled and data bit 7 is 0, the byte is a run-length code and is stored in a separate count register. Any other tagged byte enters the pipeline. It halts the automatic flow and raises an interrupt until the host reads it out of the stage that holds it. In transmit, the host inserts tagged bytes by writing stage 1 directly after setting a one-shot arm bit. Automatic DMA must be off for that write. The block also keeps the FIFO fill pointer, which gives the write address for each byte placed in the FIFO.

Top module: `tag_hold_pipe`

## Requirements
- R1: After reset both stages are empty with data 0x00, the fill pointer and all control fields are 0, irq_o, out_valid_o, fifo_we_o, fifo_re_o and rx_ready_o are low.
- R2: In receive, untagged bytes are written to the FIFO in arrival order, each at the address given by the fill pointer; the pointer steps by one per write and wraps from 63 to 0.
- R3: In transmit with DMA enabled, bytes are read from the FIFO only while it is not empty and leave on the output port untagged, in FIFO order.
- R4: With DMA disabled (control bit 0 = 0), rx_ready_o and fifo_re_o stay low.
- R5: In receive, a byte with tag = 1 that is not diverted enters the pipeline and is never written to the FIFO. While it sits in either stage, irq_o is high and rx_ready_o is low.
- R6: A host read of address 1 or 2 returns that stage's data. If the stage holds a tagged byte in receive, the read removes the byte and irq_o drops. irq_o stays high until that read. Reading a stage that holds an untagged byte leaves it in place.
- R7: In receive with control bit 1 set, a byte with tag = 1 and data bit 7 = 0 is loaded into rlc_o. It does not enter the pipeline and raises no interrupt. A tagged byte with data bit 7 = 1 is always an address.
- R8: In transmit, a host write to address 1 while stage 1 is empty loads the byte with tag equal to the arm bit (control bit 2). The arm bit clears itself once a tagged write is accepted.
- R9: A host write to address 1 while both the arm bit and DMA enable are 1 is dropped, and the arm bit stays set.
- R10: A stage loads only when it is empty. In receive, fifo_full_i holds the byte in stage 2. In transmit, while out_ready_i is low, out_valid_o and out_data_o hold steady.
- R11: Writing control bit 3 as 1 clears the fill pointer. The bit reads back as 0.
- R12: The register map is as follows. Address 0 is control: bit 0 DMA enable, bit 1 run-length enable, bit 2 arm, bit 4 direction (1 = toward the FIFO), other bits read 0. Addresses 1 and 2 are stage 1 and stage 2 data. Address 3 is the fill pointer, zero-extended. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_re_i | input | 1 | Host register read strobe (pops tagged stage) |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_tag_i | input | 1 | Receive byte tag flag |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte accepted this cycle |
| fifo_full_i | input | 1 | FIFO has no free slot |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_waddr_o | output | PTR_W | FIFO write slot (fill pointer) |
| fifo_wdata_o | output | 8 | FIFO write byte |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_rdata_i | input | 8 | FIFO head byte |
| fifo_re_o | output | 1 | FIFO read strobe |
| out_valid_o | output | 1 | Byte offered to the DMA buffer register |
| out_tag_o | output | 1 | Tag of the offered byte |
| out_data_o | output | 8 | Offered byte |
| out_ready_i | input | 1 | DMA buffer register takes the byte |
| rlc_o | output | 8 | Last captured run-length code |
| irq_o | output | 1 | Tagged receive byte awaits the host |

## Verification
The hardest case to reach is a tagged address byte stuck in stage 1 behind an untagged byte in stage 2. In that state, a read of stage 2 must leave its byte alone and a read of stage 1 must pop the tagged byte. The bench gets there by holding fifo_full_i high, so the first byte parks in stage 2, and then offering a tagged byte that can only reach stage 1. A second hard case is a pointer wrap. It is reached by streaming more than 64 receive bytes and checking every write address on the scoreboard.

// File: rtl/tag_hold_pipe_pkg.sv
`timescale 1ns/1ps
package tag_hold_pipe_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              tag;
    logic [BYTE_W-1:0] data;
  } hbyte_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ST1  = 2'd1,
    REG_ST2  = 2'd2,
    REG_FILL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_DMA  = 0;
  localparam int unsigned CTL_RLE  = 1;
  localparam int unsigned CTL_ARM  = 2;
  localparam int unsigned CTL_CLR  = 3;
  localparam int unsigned CTL_DIR  = 4;
endpackage

// File: rtl/tag_hold_stage.sv
`timescale 1ns/1ps
module tag_hold_stage
  import tag_hold_pipe_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  logic   clear_i,
  input  hbyte_t d_i,
  output logic   valid_o,
  output hbyte_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      q_o     <= d_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
endmodule

// File: rtl/tag_hold_fill.sv
`timescale 1ns/1ps
module tag_hold_fill #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (inc_i) ptr_o <= ptr_o + 1'b1;
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> ptr_o == PTR_W'($past(ptr_o) + 1'b1));

  // R11
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_o == '0);
endmodule

// File: rtl/tag_hold_pipe.sv
`timescale 1ns/1ps
module tag_hold_pipe
  import tag_hold_pipe_pkg::*;
#(
  parameter int unsigned PTR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [1:0]        host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_tag_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              fifo_full_i,
  output logic              fifo_we_o,
  output logic [PTR_W-1:0]  fifo_waddr_o,
  output logic [BYTE_W-1:0] fifo_wdata_o,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_rdata_i,
  output logic              fifo_re_o,
  output logic              out_valid_o,
  output logic              out_tag_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] rlc_o,
  output logic              irq_o
);
  localparam int unsigned NSTG = 2;

  logic dma_en_q, rle_en_q, arm_q, dir_rx_q;
  logic st_ld [NSTG];
  logic st_clr[NSTG];
  logic st_v  [NSTG];
  hbyte_t st_d[NSTG];
  hbyte_t st_q[NSTG];

  logic ctrl_wr, s1_wr, s1_wr_ok, halt, rlc_div, rx_take;
  logic pop1, pop2, mv12, s2_leave;
  logic [PTR_W-1:0] fill;

  assign ctrl_wr  = host_we_i && (host_addr_i == REG_CTRL);
  assign s1_wr    = host_we_i && (host_addr_i == REG_ST1);
  // host byte into stage 1: transmit only, tagged needs DMA off
  assign s1_wr_ok = s1_wr && !dir_rx_q && !st_v[0] && !(arm_q && dma_en_q);

  assign halt    = dir_rx_q && ((st_v[0] && st_q[0].tag) || (st_v[1] && st_q[1].tag));
  assign irq_o   = halt;
  assign rlc_div = rx_tag_i && !rx_data_i[BYTE_W-1] && rle_en_q;

  assign rx_ready_o = dir_rx_q && dma_en_q && !halt && (rlc_div || !st_v[0]);
  assign rx_take    = rx_valid_i && rx_ready_o;
  assign fifo_re_o  = !dir_rx_q && dma_en_q && !st_v[0] && !fifo_empty_i && !s1_wr_ok;

  assign pop1 = host_re_i && (host_addr_i == REG_ST1) && halt && st_v[0] && st_q[0].tag;
  assign pop2 = host_re_i && (host_addr_i == REG_ST2) && halt && st_v[1] && st_q[1].tag;
  assign mv12 = st_v[0] && !st_v[1] && !pop1;
  assign s2_leave = st_v[1] && (dir_rx_q ? (!st_q[1].tag && !fifo_full_i) : out_ready_i);

  always_comb begin
    if (s1_wr_ok)      st_d[0] = '{tag: arm_q, data: host_wdata_i};
    else if (dir_rx_q) st_d[0] = '{tag: rx_tag_i, data: rx_data_i};
    else               st_d[0] = '{tag: 1'b0, data: fifo_rdata_i};
  end
  assign st_d[1]   = st_q[0];
  assign st_ld[0]  = (rx_take && !rlc_div) || fifo_re_o || s1_wr_ok;
  assign st_clr[0] = mv12 || pop1;
  assign st_ld[1]  = mv12;
  assign st_clr[1] = s2_leave || pop2;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    tag_hold_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (st_ld[g]),
      .clear_i(st_clr[g]),
      .d_i    (st_d[g]),
      .valid_o(st_v[g]),
      .q_o    (st_q[g])
    );
  end

  tag_hold_fill #(.PTR_W(PTR_W)) u_fill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (fifo_we_o),
    .clr_i (ctrl_wr && host_wdata_i[CTL_CLR]),
    .ptr_o (fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q <= 1'b0;
      rle_en_q <= 1'b0;
      arm_q    <= 1'b0;
      dir_rx_q <= 1'b0;
      rlc_o    <= '0;
    end else begin
      if (ctrl_wr) begin
        dma_en_q <= host_wdata_i[CTL_DMA];
        rle_en_q <= host_wdata_i[CTL_RLE];
        arm_q    <= host_wdata_i[CTL_ARM];
        dir_rx_q <= host_wdata_i[CTL_DIR];
      end else if (s1_wr_ok) begin
        arm_q    <= 1'b0;
      end
      if (rx_take && rlc_div) rlc_o <= rx_data_i;
    end
  end

  assign fifo_we_o    = dir_rx_q && s2_leave;
  assign fifo_waddr_o = fill;
  assign fifo_wdata_o = st_q[1].data;
  assign out_valid_o  = !dir_rx_q && st_v[1];
  assign out_tag_o    = st_q[1].tag;
  assign out_data_o   = st_q[1].data;

  always_comb begin
    host_rdata_o = '0;
    case (host_addr_i)
      REG_CTRL: begin
        host_rdata_o[CTL_DMA] = dma_en_q;
        host_rdata_o[CTL_RLE] = rle_en_q;
        host_rdata_o[CTL_ARM] = arm_q;
        host_rdata_o[CTL_DIR] = dir_rx_q;
      end
      REG_ST1:  host_rdata_o = st_q[0].data;
      REG_ST2:  host_rdata_o = st_q[1].data;
      default:  host_rdata_o = BYTE_W'(fill);
    endcase
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !host_re_i && !host_we_i) |=> irq_o);

  // R9
  arm_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && dma_en_q && s1_wr) |=> arm_q);

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !host_re_i && !host_we_i) |=>
      (out_valid_o && $stable(out_data_o)));

  // R5
  rx_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!rx_ready_o && !(fifo_we_o && out_tag_o)));
endmodule

// File: tb/tag_hold_pipe_tb.sv
`timescale 1ns/1ps
module tag_hold_pipe_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_we_i = 0, host_re_i = 0;
  logic [1:0] host_addr_i = 0;
  logic [7:0] host_wdata_i = 0, host_rdata_o;
  logic       rx_valid_i = 0, rx_tag_i = 0, rx_ready_o;
  logic [7:0] rx_data_i = 0;
  logic       fifo_full_i = 0, fifo_we_o, fifo_re_o, fifo_empty_i;
  logic [5:0] fifo_waddr_o;
  logic [7:0] fifo_wdata_o, fifo_rdata_i;
  logic       out_valid_o, out_tag_o, out_ready_i = 1;
  logic [7:0] out_data_o, rlc_o;
  logic       irq_o;

  always #4 clk_i = ~clk_i;

  tag_hold_pipe u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [13:0] rx_q[$];
  logic [8:0]  tx_q[$];
  logic [5:0]  exp_fill = 0;

  logic [7:0] src_mem[64];
  int src_wr = 0, src_rd = 0;
  assign fifo_empty_i = (src_rd == src_wr);
  assign fifo_rdata_i = src_mem[src_rd[5:0]];
  always @(posedge clk_i) if (fifo_re_o) src_rd <= src_rd + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (fifo_we_o) begin
      if (rx_q.size() == 0) chk(0, "R5", "unexpected fifo write", fifo_wdata_o, 0);
      else begin
        logic [13:0] e;
        e = rx_q.pop_front();
        chk({fifo_waddr_o, fifo_wdata_o} == e, "R2", "fifo write addr/data",
            {fifo_waddr_o, fifo_wdata_o}, e);
      end
    end
    if (out_valid_o && out_ready_i) begin
      if (tx_q.size() == 0) chk(0, "R9", "unexpected output byte", out_data_o, 0);
      else begin
        logic [8:0] e;
        e = tx_q.pop_front();
        chk({out_tag_o, out_data_o} == e, "R3", "output tag/data",
            {out_tag_o, out_data_o}, e);
      end
    end
  end

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    @(posedge clk_i); #1;
    host_we_i = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk_i); #1;
    host_re_i = 1; host_addr_i = a;
    @(negedge clk_i); d = host_rdata_o;
    @(posedge clk_i); #1;
    host_re_i = 0;
  endtask

  task automatic send_rx(input logic tag, input logic [7:0] d);
    logic acc;
    if (!tag) begin rx_q.push_back({exp_fill, d}); exp_fill++; end
    @(posedge clk_i); #1;
    rx_valid_i = 1; rx_tag_i = tag; rx_data_i = d;
    do begin
      @(negedge clk_i); acc = rx_ready_o;
      @(posedge clk_i); #1;
    end while (!acc);
    rx_valid_i = 0; rx_tag_i = 0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 300 && (rx_q.size() != 0 || tx_q.size() != 0); i++)
      @(negedge clk_i);
    chk(rx_q.size() == 0 && tx_q.size() == 0, req, "scoreboard drained",
        rx_q.size() + tx_q.size(), 0);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] rd, held;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    @(negedge clk_i);
    chk(irq_o == 0 && out_valid_o == 0 && fifo_we_o == 0 && fifo_re_o == 0,
        "R1", "outputs idle", {irq_o, out_valid_o, fifo_we_o, fifo_re_o}, 0);
    host_rd(2'd0, rd); chk(rd == 8'h00, "R1", "ctrl reset", rd, 0);
    host_rd(2'd1, rd); chk(rd == 8'h00, "R1", "stage1 reset", rd, 0);
    host_rd(2'd3, rd); chk(rd == 8'h00, "R1", "fill reset", rd, 0);

    // R4 DMA off blocks receive
    host_wr(2'd0, 8'h10);
    rx_valid_i = 1; rx_data_i = 8'h99;
    repeat (3) @(negedge clk_i);
    chk(rx_ready_o == 0, "R4", "rx_ready with dma off", rx_ready_o, 0);
    rx_valid_i = 0;

    // R2 stream with pointer wrap
    host_wr(2'd0, 8'h11);
    for (int i = 0; i < 70; i++) send_rx(1'b0, 8'(i * 3 + 1));
    drain("R2");
    host_rd(2'd3, rd); chk(rd == 8'd6, "R2", "fill after wrap", rd, 6);

    // R10 full stalls receive
    fifo_full_i = 1;
    send_rx(1'b0, 8'h40);
    send_rx(1'b0, 8'h41);
    rx_valid_i = 1; rx_data_i = 8'h42;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(rx_ready_o == 0 && fifo_we_o == 0, "R10", "stall while full",
          {rx_ready_o, fifo_we_o}, 0);
    end
    rx_valid_i = 0;
    fifo_full_i = 0;
    drain("R10");
    send_rx(1'b0, 8'h42);
    drain("R10");

    // R5 tagged address halts, R6 read of stage 2 clears
    send_rx(1'b0, 8'h11);
    send_rx(1'b1, 8'h85);
    repeat (4) @(negedge clk_i);
    chk(irq_o == 1, "R5", "irq on tagged byte", irq_o, 1);
    rx_valid_i = 1; rx_data_i = 8'h22;
    @(negedge clk_i);
    chk(rx_ready_o == 0, "R5", "rx halted", rx_ready_o, 0);
    rx_valid_i = 0;
    host_rd(2'd2, rd); chk(rd == 8'h85, "R6", "tagged byte in stage2", rd, 8'h85);
    @(negedge clk_i);
    chk(irq_o == 0, "R6", "irq cleared by read", irq_o, 0);
    send_rx(1'b0, 8'h22);
    drain("R5");

    // R6 tagged byte stuck in stage 1 behind stalled stage 2
    fifo_full_i = 1;
    send_rx(1'b0, 8'h33);
    send_rx(1'b1, 8'h9A);
    repeat (2) @(negedge clk_i);
    chk(irq_o == 1, "R5", "irq with tag in stage1", irq_o, 1);
    host_rd(2'd2, rd); chk(rd == 8'h33, "R12", "stage2 data read", rd, 8'h33);
    @(negedge clk_i);
    chk(irq_o == 1, "R6", "untagged read keeps irq", irq_o, 1);
    host_rd(2'd1, rd); chk(rd == 8'h9A, "R6", "stage1 tagged read", rd, 8'h9A);
    @(negedge clk_i);
    chk(irq_o == 0, "R6", "irq cleared by stage1 read", irq_o, 0);
    fifo_full_i = 0;
    drain("R6");

    // R7 run-length code diverted
    host_wr(2'd0, 8'h13);
    send_rx(1'b1, 8'h05);
    repeat (3) @(negedge clk_i);
    chk(rlc_o == 8'h05, "R7", "run-length capture", rlc_o, 5);
    chk(irq_o == 0, "R7", "no irq for run-length", irq_o, 0);
    drain("R7");

    // R11 FIFO reset clears fill pointer
    host_rd(2'd3, rd); chk(rd != 8'h00, "R11", "fill nonzero before clear", rd, 1);
    host_wr(2'd0, 8'h18);
    host_rd(2'd3, rd); chk(rd == 8'h00, "R11", "fill cleared", rd, 0);
    host_rd(2'd0, rd); chk(rd == 8'h10, "R11", "clear bit reads 0", rd, 8'h10);
    exp_fill = 0;
    host_wr(2'd0, 8'h11);
    send_rx(1'b0, 8'h50);
    drain("R11");

    // R3 transmit from FIFO
    host_wr(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      src_mem[src_wr[5:0]] = 8'hA0 + 8'(i);
      tx_q.push_back({1'b0, 8'hA0 + 8'(i)});
      src_wr++;
    end
    host_wr(2'd0, 8'h01);
    drain("R3");
    chk(fifo_empty_i == 1, "R3", "fifo fully read", fifo_empty_i, 1);

    // R10 output held while not ready
    out_ready_i = 0;
    for (int i = 0; i < 2; i++) begin
      src_mem[src_wr[5:0]] = 8'hB0 + 8'(i);
      tx_q.push_back({1'b0, 8'hB0 + 8'(i)});
      src_wr++;
    end
    repeat (6) @(negedge clk_i);
    chk(out_valid_o == 1, "R10", "output offered", out_valid_o, 1);
    held = out_data_o;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1 && out_data_o == held, "R10", "output held",
        out_data_o, held);
    out_ready_i = 1;
    drain("R10");

    // R8 armed tagged write
    host_wr(2'd0, 8'h04);
    host_rd(2'd0, rd); chk(rd == 8'h04, "R8", "arm readback", rd, 4);
    tx_q.push_back({1'b1, 8'hC3});
    host_wr(2'd1, 8'hC3);
    drain("R8");
    host_rd(2'd0, rd); chk(rd == 8'h00, "R8", "arm self-clear", rd, 0);
    tx_q.push_back({1'b0, 8'h44});
    host_wr(2'd1, 8'h44);
    drain("R8");

    // R9 tagged write with DMA on dropped
    host_wr(2'd0, 8'h05);
    host_wr(2'd1, 8'h77);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(out_valid_o == 0, "R9", "dropped write not output", out_valid_o, 0);
    end
    host_rd(2'd0, rd); chk(rd == 8'h05, "R9", "arm kept", rd, 5);
    host_wr(2'd0, 8'h00);

    report();
  end
endmodule